// File: doc/BRIEF.md
# Buffer Release Entry Dispatcher

The dispatcher takes eight-dword release entries from an input stream and steers each one to exactly one of fourteen destination queues. The queues are a buffer idle list, four per-chip link-descriptor idle lists, a firmware queue, seven software rings and one error queue. The choice depends on two fields read together: the 4-bit return-manager code and the 3-bit descriptor type. If the descriptor type does not fit the list the manager code names, the block rewrites the entry and sends it to the error queue instead of the named list.

There is one registered holding slot. It presents the entry on a shared output data bus, with a valid bit raised only for the chosen destination. Each destination has its own ready bit. The slot drains when that ready bit is high. A new entry can load in the same cycle that the previous one drains, so a stream with no back-pressure moves one entry per cycle. Entries to the same destination leave in the order they arrived.

Top module: `rel_dispatch`

## Requirements
- R1: After reset, every `outValid` bit is 0 and `inReady` is 1.
- R2: Manager code 0 with type 0 (plain buffer) goes to destination 0, the buffer idle list. An all-zero (null) entry also goes there.
- R3: Manager codes 1, 2, 3 and 12 name chip lists 0, 1, 2 and 3 (destinations 1 to 4). An entry with one of these codes and a link type (1, 2 or 4) goes to that chip's list.
- R4: Type 3 (extension descriptor) goes to destination 5, firmware, when the manager code is 0, 1, 2, 3 or 12. Manager code 4 goes to firmware for any type.
- R5: Manager codes 5 to 11 go to software rings 0 to 6 (destinations 6 to 12) for any type.
- R6: A type mismatch goes to destination 13, the error queue. Type 0 with a chip-list code gets error code 1. Types 1, 2 or 4 with manager code 0 get error code 2.
- R7: Manager codes 13 to 15 go to the error queue with error code 3, whatever the type. Types 5 to 7 with manager codes 0 to 3 or 12 get error code 4.
- R8: The entry bus packs dword k in bits 32k+31 down to 32k. The manager code is in bits 43:40 and the type is in bits 72:70. An entry sent to the error queue has bit 95 set and bits 255:252 set to its error code. Any other entry has bit 95 cleared. All remaining bits pass through unchanged.
- R9: At most one `outValid` bit is high in any cycle.
- R10: While the selected ready bit is low, `outValid` and `outEntry` hold their values and `inReady` is 0.
- R11: When the held entry drains, a waiting entry loads in the same cycle, so back-to-back entries come out on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input entry valid |
| inReady | output | 1 | Input entry accepted when high with inValid |
| inEntry | input | 256 | Input release entry, eight dwords |
| outValid | output | 14 | One valid bit per destination |
| outReady | input | 14 | One ready bit per destination |
| outEntry | output | 256 | Held entry, possibly rewritten |

## Verification
The holding slot can drain one entry and load the next in the same clock edge. This happens in two cases. The first is back-to-back input with every ready bit high. The second is a stall on the firmware ready bit, released while a buffer-list entry is already waiting. In each case the bench checks that the second entry appears one cycle after the first leaves, with the right valid bit and data. The whole code-by-type grid is also swept against a routing table written from the requirements.

// File: rtl/rel_dispatch_pkg.sv
package rel_dispatch_pkg;
  localparam int DWORD_W      = 32;
  localparam int ENTRY_DWORDS = 8;
  localparam int ENTRY_W      = DWORD_W * ENTRY_DWORDS;

  localparam int NUM_CHIP_LISTS = 4;
  localparam int NUM_SW_RINGS   = 7;
  localparam int DEST_BUF   = 0;
  localparam int DEST_LINK0 = 1;
  localparam int DEST_FW    = DEST_LINK0 + NUM_CHIP_LISTS;
  localparam int DEST_SW0   = DEST_FW + 1;
  localparam int DEST_ERR   = DEST_SW0 + NUM_SW_RINGS;
  localparam int NUM_DEST   = DEST_ERR + 1;
  localparam int DEST_W     = $clog2(NUM_DEST);

  // field positions inside the flattened entry
  localparam int MGR_LSB   = DWORD_W + 8;
  localparam int MGR_W     = 4;
  localparam int TYPE_LSB  = 2 * DWORD_W + 6;
  localparam int TYPE_W    = 3;
  localparam int IERR_BIT  = 2 * DWORD_W + 31;
  localparam int ECODE_W   = 4;
  localparam int ECODE_LSB = ENTRY_W - ECODE_W;

  localparam logic [ECODE_W-1:0] ERR_BUF_TO_LINK = 4'd1;
  localparam logic [ECODE_W-1:0] ERR_LINK_TO_BUF = 4'd2;
  localparam logic [ECODE_W-1:0] ERR_BAD_MGR     = 4'd3;
  localparam logic [ECODE_W-1:0] ERR_BAD_TYPE    = 4'd4;

  typedef struct packed {
    logic load;
    logic drain;
  } ctlStrobes_t;
endpackage

// File: rtl/rel_dispatch_dp.sv
module rel_dispatch_dp
  import rel_dispatch_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        strobes,
  input  logic [ENTRY_W-1:0] inEntry,
  output logic [ENTRY_W-1:0] heldEntry,
  output logic [DEST_W-1:0]  heldDest
);
  logic [MGR_W-1:0]   mgr;
  logic [TYPE_W-1:0]  typ;
  logic [DEST_W-1:0]  nextDest;
  logic [ECODE_W-1:0] errCode;
  logic               isErr;
  logic [ENTRY_W-1:0] rewritten;
  logic               isLinkType;
  logic [DEST_W-1:0]  chipIdx;

  assign mgr = inEntry[MGR_LSB +: MGR_W];
  assign typ = inEntry[TYPE_LSB +: TYPE_W];
  assign isLinkType = (typ == 3'd1) || (typ == 3'd2) || (typ == 3'd4);
  assign chipIdx = (mgr == 4'd12) ? DEST_W'(3) : DEST_W'(mgr - 4'd1);

  // joint decode of manager code and type
  always_comb begin
    nextDest = DEST_W'(DEST_ERR);
    errCode  = '0;
    isErr    = 1'b0;
    if (mgr > 4'd12) begin
      isErr   = 1'b1;
      errCode = ERR_BAD_MGR;
    end else if (mgr == 4'd4) begin
      nextDest = DEST_W'(DEST_FW);
    end else if (mgr >= 4'd5 && mgr <= 4'd11) begin
      nextDest = DEST_W'(DEST_SW0) + DEST_W'(mgr - 4'd5);
    end else if (typ == 3'd3) begin
      nextDest = DEST_W'(DEST_FW);
    end else if (typ > 3'd4) begin
      isErr   = 1'b1;
      errCode = ERR_BAD_TYPE;
    end else if (mgr == 4'd0) begin
      if (typ == 3'd0) nextDest = DEST_W'(DEST_BUF);
      else begin
        isErr   = 1'b1;
        errCode = ERR_LINK_TO_BUF;
      end
    end else begin
      if (isLinkType) nextDest = DEST_W'(DEST_LINK0) + chipIdx;
      else begin
        isErr   = 1'b1;
        errCode = ERR_BUF_TO_LINK;
      end
    end
  end

  always_comb begin
    rewritten = inEntry;
    rewritten[IERR_BIT] = isErr;
    if (isErr) rewritten[ECODE_LSB +: ECODE_W] = errCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldEntry <= '0;
      heldDest  <= '0;
    end else if (strobes.load) begin
      heldEntry <= rewritten;
      heldDest  <= nextDest;
    end
  end

  // R8
  err_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (heldDest == DEST_W'(DEST_ERR)) == heldEntry[IERR_BIT]);
endmodule

// File: rtl/rel_dispatch_ctl.sv
module rel_dispatch_ctl
  import rel_dispatch_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [NUM_DEST-1:0] outReady,
  input  logic [DEST_W-1:0]   heldDest,
  output logic [NUM_DEST-1:0] outValid,
  output ctlStrobes_t         strobes
);
  logic slotFull;
  logic selReady;

  assign selReady      = outReady[heldDest];
  assign strobes.drain = slotFull && selReady;
  assign inReady       = !slotFull || strobes.drain;
  assign strobes.load  = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN) slotFull <= 1'b0;
    else if (strobes.load) slotFull <= 1'b1;
    else if (strobes.drain) slotFull <= 1'b0;
  end

  for (genvar d = 0; d < NUM_DEST; d++) begin : g_valid
    assign outValid[d] = slotFull && (heldDest == DEST_W'(d));
  end

  // R9
  onehot_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outValid));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotFull && !selReady) |=> (outValid == $past(outValid)));

  // R11
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (outValid != '0));
endmodule

// File: rtl/rel_dispatch.sv
module rel_dispatch
  import rel_dispatch_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [ENTRY_W-1:0]  inEntry,
  output logic [NUM_DEST-1:0] outValid,
  input  logic [NUM_DEST-1:0] outReady,
  output logic [ENTRY_W-1:0]  outEntry
);
  ctlStrobes_t       strobes;
  logic [DEST_W-1:0] heldDest;

  rel_dispatch_ctl u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outReady(outReady), .heldDest(heldDest), .outValid(outValid),
    .strobes(strobes)
  );

  rel_dispatch_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inEntry(inEntry),
    .heldEntry(outEntry), .heldDest(heldDest)
  );

  // R10
  stall_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((outValid != '0) && ((outValid & outReady) == '0)) |=> $stable(outEntry));
endmodule

// File: tb/sim_rel_dispatch.sv
module sim_rel_dispatch;
  import rel_dispatch_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [ENTRY_W-1:0] inEntry = '0;
  logic [NUM_DEST-1:0] outValid;
  logic [NUM_DEST-1:0] outReady = '1;
  logic [ENTRY_W-1:0] outEntry;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rel_dispatch u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inEntry(inEntry), .outValid(outValid), .outReady(outReady),
    .outEntry(outEntry)
  );

  function automatic logic [ENTRY_W-1:0] mkEntry(int mgr, int typ, int seed);
    logic [ENTRY_W-1:0] e;
    for (int k = 0; k < ENTRY_DWORDS; k++)
      e[k*32 +: 32] = 32'h9E37_79B9 * (seed + k + 1);
    e[43:40] = 4'(mgr);
    e[72:70] = 3'(typ);
    return e;
  endfunction

  // routing table from R2..R7; returns dest, sets error code
  function automatic int refDest(int mgr, int typ, output int ecode);
    ecode = 0;
    if (mgr >= 13) begin ecode = 3; return 13; end
    if (mgr == 4) return 5;
    if (mgr >= 5 && mgr <= 11) return 6 + mgr - 5;
    if (typ == 3) return 5;
    if (typ >= 5) begin ecode = 4; return 13; end
    if (mgr == 0) begin
      if (typ == 0) return 0;
      ecode = 2; return 13;
    end
    if (typ == 0) begin ecode = 1; return 13; end
    return (mgr == 12) ? 4 : mgr;
  endfunction

  function automatic logic [ENTRY_W-1:0] refEntry(logic [ENTRY_W-1:0] e, int ecode);
    logic [ENTRY_W-1:0] r = e;
    r[95] = (ecode != 0);
    if (ecode != 0) r[255:252] = 4'(ecode);
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [ENTRY_W-1:0] act, logic [ENTRY_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkOut(string req, int dest, logic [ENTRY_W-1:0] expE);
    logic [NUM_DEST-1:0] expV = NUM_DEST'(1) << dest;
    check(outValid == expV, req, "outValid", ENTRY_W'(outValid), ENTRY_W'(expV));
    check(outEntry == expE, req, "outEntry", outEntry, expE);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == '0, "R1", "outValid", ENTRY_W'(outValid), '0);
    check(inReady == 1'b1, "R1", "inReady", ENTRY_W'(inReady), ENTRY_W'(1));
  endtask

  task automatic sendOne(string req, logic [ENTRY_W-1:0] e, int dest, int ecode);
    inEntry = e;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkOut(req, dest, refEntry(e, ecode));
    @(negedge clk);
  endtask

  task automatic testNull();
    sendOne("R2", '0, 0, 0);
  endtask

  task automatic testGrid();
    for (int m = 0; m < 16; m++)
      for (int t = 0; t < 8; t++) begin
        int ec;
        int d = refDest(m, t, ec);
        logic [ENTRY_W-1:0] e = mkEntry(m, t, m * 8 + t);
        string req;
        if (ec == 3 || ec == 4) req = "R7";
        else if (ec != 0) req = "R6";
        else if (d == 0) req = "R2";
        else if (d <= 4) req = "R3";
        else if (d == 5) req = "R4";
        else req = "R5";
        e[95] = t[0];
        sendOne(req, e, d, ec);
        if (ec != 0 || t[0]) begin
          check(outValid == '0, "R8", "drained", ENTRY_W'(outValid), '0);
        end
      end
  endtask

  task automatic testBackToBack();
    logic [ENTRY_W-1:0] a = mkEntry(7, 2, 500);
    logic [ENTRY_W-1:0] b = mkEntry(13, 0, 501);
    inEntry = a; inValid = 1'b1;
    @(negedge clk);
    checkOut("R11", 8, refEntry(a, 0));
    check(inReady == 1'b1, "R11", "inReady", ENTRY_W'(inReady), ENTRY_W'(1));
    inEntry = b;
    @(negedge clk);
    inValid = 1'b0;
    checkOut("R11", 13, refEntry(b, 3));
    @(negedge clk);
  endtask

  task automatic testStall();
    logic [ENTRY_W-1:0] a = mkEntry(4, 6, 600);
    logic [ENTRY_W-1:0] b = mkEntry(0, 0, 601);
    outReady = ~(NUM_DEST'(1) << 5);
    inEntry = a; inValid = 1'b1;
    @(negedge clk);
    inEntry = b;
    for (int i = 0; i < 3; i++) begin
      checkOut("R10", 5, refEntry(a, 0));
      check(inReady == 1'b0, "R10", "inReady", ENTRY_W'(inReady), '0);
      @(negedge clk);
    end
    outReady = '1;
    #1;
    check(inReady == 1'b1, "R11", "inReady", ENTRY_W'(inReady), ENTRY_W'(1));
    @(negedge clk);
    inValid = 1'b0;
    checkOut("R11", 0, refEntry(b, 0));
    @(negedge clk);
    check(outValid == '0, "R9", "idle", ENTRY_W'(outValid), '0);
  endtask

  initial begin
    testReset();
    testNull();
    testGrid();
    testBackToBack();
    testStall();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule